// File: doc/BRIEF.md
# PTP Receive Timestamp Filter

This block sits beside a receive parser. For every received frame it decides whether the arrival time should be kept. The parser presents one metadata strobe per frame, which carries:
- a raw-Ethernet PTP flag;
- a UDP flag and the UDP destination port;
- the PTP version;
- the message type.

A free-running time value arrives alongside the strobe. When the frame qualifies, that time is latched into one of a small pool of capture slots, and the slot's valid flag is raised.

A 32-bit control word sets how strict the filter is. Bit 31 enables capture. A 2-bit mode picks version-1 over UDP, version-2 with a message-type match, or version-2 event messages only. A 2-bit field selects which UDP ports qualify: the event port 319, the general port 320, or both. The slot pool is tiny, so the filter should be as strict as possible. Non-event frames then cannot take a slot that a later event frame needs.

Software reads a slot's low word and then its high word. Reading the high word hands the slot back. When no slot is free, the time is dropped and a saturating drop counter advances.

Top module: `ptp_rx_ts_filter`

## Requirements
- R1: After reset, every slot valid flag is 0, the control word reads 0 and the drop counter reads 0.
- R2: No slot is filled when control bit 31 is 0 or when the mode field (bits 25:24) is 0.
- R3: Mode 1 captures only frames with version 1 and the UDP flag set on an enabled port. Raw-Ethernet version-1 frames and frames of any other version are not captured.
- R4: Mode 2 captures version-2 frames when the message type equals the match field (bits 19:16). A match field of 0xF accepts every message type.
- R5: Mode 3 captures version-2 frames, raw-Ethernet or UDP, only when the message type is below 8. The match field is ignored.
- R6: Port enable bits 27:26 work as follows:
  - Bit 26 admits UDP destination port 319.
  - Bit 27 admits UDP destination port 320.
  - A UDP frame on any port that is not admitted is never captured.
  - A frame with neither the UDP flag nor the raw-Ethernet flag is never captured.
- R7: A qualifying frame stores the time present on its strobe cycle into the lowest-numbered free slot. That slot's valid flag is 1 from the next cycle onward.
- R8: The register map is as follows; a read returns its data one cycle after the read strobe:
  - address 0: control word, read/write;
  - address 1: drop counter, read-only;
  - address 2+2k: low 32 bits of slot k;
  - address 3+2k: high 32 bits of slot k.
- R9: A read of address 3+2k clears the valid flag of slot k.
- R10: A release and a capture landing on the same slot in one cycle leave the slot valid and holding the new time. The read returns the old high word.
- R11: A qualifying frame that finds all slots occupied is dropped. The drop counter then increments, and it saturates at its all-ones value (255 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_vld_i | input | 1 | Per-frame metadata strobe |
| frm_l2_i | input | 1 | PTP carried directly in an Ethernet frame |
| frm_udp_i | input | 1 | PTP carried over UDP |
| frm_dport_i | input | 16 | UDP destination port |
| frm_ver_i | input | 4 | PTP version |
| frm_type_i | input | 4 | PTP message type |
| time_i | input | 64 | Free-running time value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the read |
| slot_vld_o | output | 4 | Per-slot valid flags |

## Verification
A software release and a new capture can arrive in the same cycle. The bench provokes this by filling all four slots. It then asserts the read strobe on slot 2's high word on the same clock as a qualifying frame strobe. Three results are expected:
- The read returns slot 2's old high word.
- All four valid flags stay set.
- Slot 2's low word now holds the new time, and the drop counter is still 0.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_V1_UDP = 2'd1,
    MODE_V2_ANY = 2'd2,
    MODE_V2_EVT = 2'd3
  } ts_mode_e;

  localparam int CTL_EN_BIT    = 31;
  localparam int CTL_PORT_LSB  = 26;
  localparam int CTL_MODE_LSB  = 24;
  localparam int CTL_MATCH_LSB = 16;

  localparam logic [15:0] PORT_EVENT   = 16'd319;
  localparam logic [15:0] PORT_GENERAL = 16'd320;
  localparam logic [3:0]  MATCH_ANY    = 4'hF;

  typedef struct packed {
    logic       en;
    logic [1:0] port_en;
    ts_mode_e   mode;
    logic [3:0] match;
  } ts_ctl_t;

  function automatic ts_ctl_t ctl_decode(input logic [31:0] w);
    ts_ctl_t c;
    c.en      = w[CTL_EN_BIT];
    c.port_en = w[CTL_PORT_LSB+:2];
    c.mode    = ts_mode_e'(w[CTL_MODE_LSB+:2]);
    c.match   = w[CTL_MATCH_LSB+:4];
    return c;
  endfunction
endpackage

// File: rtl/ptp_ts_qualify.sv
module ptp_ts_qualify
  import ptp_ts_pkg::*;
(
  input  ts_ctl_t     ctl_i,
  input  logic        frm_vld_i,
  input  logic        frm_l2_i,
  input  logic        frm_udp_i,
  input  logic [15:0] frm_dport_i,
  input  logic [3:0]  frm_ver_i,
  input  logic [3:0]  frm_type_i,
  output logic        hit_o
);
  logic port_ok, xport_ok, type_ok, raw;

  assign port_ok  = frm_udp_i &
                    ((frm_dport_i == PORT_EVENT   & ctl_i.port_en[0]) |
                     (frm_dport_i == PORT_GENERAL & ctl_i.port_en[1]));
  // udp flag decides transport; raw-ethernet frames need the l2 flag
  assign xport_ok = frm_udp_i ? port_ok : frm_l2_i;
  assign type_ok  = (ctl_i.match == MATCH_ANY) | (frm_type_i == ctl_i.match);

  always_comb begin
    unique case (ctl_i.mode)
      MODE_V1_UDP: raw = (frm_ver_i == 4'd1) & frm_udp_i & port_ok;
      MODE_V2_ANY: raw = (frm_ver_i == 4'd2) & xport_ok & type_ok;
      MODE_V2_EVT: raw = (frm_ver_i == 4'd2) & xport_ok & ~frm_type_i[3];
      default:     raw = 1'b0;
    endcase
  end

  assign hit_o = frm_vld_i & ctl_i.en & raw;
endmodule

// File: rtl/ptp_ts_slot_pool.sv
module ptp_ts_slot_pool #(
  parameter int NUM_SLOTS = 4,
  parameter int TS_W      = 64,
  parameter int OVF_W     = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           hit_i,
  input  logic [TS_W-1:0]                time_i,
  input  logic [NUM_SLOTS-1:0]           rel_mask_i,
  output logic [NUM_SLOTS-1:0]           slot_vld_o,
  output logic [NUM_SLOTS-1:0][TS_W-1:0] slot_ts_o,
  output logic [NUM_SLOTS-1:0]           cap_mask_o,
  output logic [OVF_W-1:0]               ovf_cnt_o
);
  logic [NUM_SLOTS-1:0] free, pick;
  logic                 drop;

  // a slot being released this cycle counts as free
  assign free = ~slot_vld_o | rel_mask_i;

  always_comb begin
    pick = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (free[k]) pick = NUM_SLOTS'(1) << k;
    end
  end

  assign cap_mask_o = hit_i ? pick : '0;
  assign drop       = hit_i & ~|free;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_vld_o[k] <= 1'b0;
        slot_ts_o[k]  <= '0;
      end else if (cap_mask_o[k]) begin
        slot_vld_o[k] <= 1'b1;
        slot_ts_o[k]  <= time_i;
      end else if (rel_mask_i[k]) begin
        slot_vld_o[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_cnt_o <= '0;
    else if (drop && ~&ovf_cnt_o)     ovf_cnt_o <= ovf_cnt_o + 1'b1;
  end
endmodule

// File: rtl/ptp_ts_regs.sv
module ptp_ts_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int DW        = 32,
  parameter int OVF_W     = 8,
  localparam int TS_W     = 2 * DW,
  localparam int AW       = $clog2(2 + 2 * NUM_SLOTS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_wr_i,
  input  logic                           reg_rd_i,
  input  logic [AW-1:0]                  reg_addr_i,
  input  logic [DW-1:0]                  reg_wdata_i,
  output logic [DW-1:0]                  reg_rdata_o,
  input  logic [NUM_SLOTS-1:0][TS_W-1:0] slot_ts_i,
  input  logic [OVF_W-1:0]               ovf_cnt_i,
  output logic [DW-1:0]                  ctl_o,
  output logic [NUM_SLOTS-1:0]           rel_mask_o
);
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctl_o <= '0;
    else if (reg_wr_i && reg_addr_i == '0)    ctl_o <= reg_wdata_i;
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_rel
    assign rel_mask_o[k] = reg_rd_i & (reg_addr_i == AW'(2 * k + 3));
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == AW'(0)) rd_mux = ctl_o;
    if (reg_addr_i == AW'(1)) rd_mux = DW'(ovf_cnt_i);
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (reg_addr_i == AW'(2 * k + 2)) rd_mux = slot_ts_i[k][DW-1:0];
      if (reg_addr_i == AW'(2 * k + 3)) rd_mux = slot_ts_i[k][TS_W-1:DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/ptp_rx_ts_filter.sv
module ptp_rx_ts_filter
  import ptp_ts_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DW        = 32,
  parameter int OVF_W     = 8,
  localparam int TS_W     = 2 * DW,
  localparam int AW       = $clog2(2 + 2 * NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frm_vld_i,
  input  logic                 frm_l2_i,
  input  logic                 frm_udp_i,
  input  logic [15:0]          frm_dport_i,
  input  logic [3:0]           frm_ver_i,
  input  logic [3:0]           frm_type_i,
  input  logic [TS_W-1:0]      time_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic [NUM_SLOTS-1:0] slot_vld_o
);
  logic [DW-1:0]                  ctl_word;
  ts_ctl_t                        ctl;
  logic                           hit;
  logic [NUM_SLOTS-1:0]           rel_mask, cap_mask;
  logic [NUM_SLOTS-1:0][TS_W-1:0] slot_ts;
  logic [OVF_W-1:0]               ovf_cnt;

  assign ctl = ctl_decode(ctl_word);

  ptp_ts_qualify u_qual (
    .ctl_i       (ctl),
    .frm_vld_i   (frm_vld_i),
    .frm_l2_i    (frm_l2_i),
    .frm_udp_i   (frm_udp_i),
    .frm_dport_i (frm_dport_i),
    .frm_ver_i   (frm_ver_i),
    .frm_type_i  (frm_type_i),
    .hit_o       (hit)
  );

  ptp_ts_slot_pool #(.NUM_SLOTS(NUM_SLOTS), .TS_W(TS_W), .OVF_W(OVF_W)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .time_i     (time_i),
    .rel_mask_i (rel_mask),
    .slot_vld_o (slot_vld_o),
    .slot_ts_o  (slot_ts),
    .cap_mask_o (cap_mask),
    .ovf_cnt_o  (ovf_cnt)
  );

  ptp_ts_regs #(.NUM_SLOTS(NUM_SLOTS), .DW(DW), .OVF_W(OVF_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .slot_ts_i   (slot_ts),
    .ovf_cnt_i   (ovf_cnt),
    .ctl_o       (ctl_word),
    .rel_mask_o  (rel_mask)
  );
endmodule

// File: rtl/ptp_rx_ts_filter_chk.sv
module ptp_rx_ts_filter_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int OVF_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frm_vld_i,
  input logic                 ctl_en_i,
  input logic [1:0]           ctl_mode_i,
  input logic                 hit_i,
  input logic [NUM_SLOTS-1:0] slot_vld_i,
  input logic [NUM_SLOTS-1:0] cap_mask_i,
  input logic [NUM_SLOTS-1:0] rel_mask_i,
  input logic [OVF_W-1:0]     ovf_cnt_i
);
  a_r2_off_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i && (!ctl_en_i || ctl_mode_i == 2'd0)
    |=> (slot_vld_i & ~$past(slot_vld_i)) == '0);

  a_r7_first_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && slot_vld_i == '0 |=> slot_vld_i[0]);

  a_r7_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cap_mask_i));

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rel_mask_i & ~cap_mask_i)
    |=> (slot_vld_i & $past(rel_mask_i & ~cap_mask_i)) == '0);

  a_r10_release_and_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rel_mask_i & cap_mask_i)
    |=> (slot_vld_i & $past(rel_mask_i & cap_mask_i)) == $past(rel_mask_i & cap_mask_i));

  a_r11_drop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && (&(slot_vld_i & ~rel_mask_i)) && !(&ovf_cnt_i)
    |=> ovf_cnt_i == $past(ovf_cnt_i) + 1'b1);

  a_r11_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &ovf_cnt_i |=> &ovf_cnt_i);
endmodule

bind ptp_rx_ts_filter ptp_rx_ts_filter_chk #(.NUM_SLOTS(NUM_SLOTS), .OVF_W(OVF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frm_vld_i  (frm_vld_i),
  .ctl_en_i   (ctl.en),
  .ctl_mode_i (ctl.mode),
  .hit_i      (hit),
  .slot_vld_i (slot_vld_o),
  .cap_mask_i (cap_mask),
  .rel_mask_i (rel_mask),
  .ovf_cnt_i  (ovf_cnt)
);

// File: tb/ptp_rx_ts_filter_bench.sv
`timescale 1ns/1ps
module ptp_rx_ts_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_vld = 0, frm_l2 = 0, frm_udp = 0;
  logic [15:0] frm_dport = '0;
  logic [3:0]  frm_ver = '0, frm_type = '0;
  logic [63:0] tstamp = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  slot_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptp_rx_ts_filter u_ptp_rx_ts_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .frm_vld_i(frm_vld), .frm_l2_i(frm_l2), .frm_udp_i(frm_udp),
    .frm_dport_i(frm_dport), .frm_ver_i(frm_ver), .frm_type_i(frm_type),
    .time_i(tstamp),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .slot_vld_o(slot_vld)
  );

  typedef struct packed {
    logic        en;
    logic [1:0]  ports;
    logic [1:0]  mode;
    logic [3:0]  match;
    logic        l2;
    logic        udp;
    logic [15:0] dport;
    logic [3:0]  ver;
    logic [3:0]  typ;
    logic        exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd3, 2'd3, 4'h0, 1'b1, 1'b0, 16'd0,    4'd2, 4'h0, 1'b0}, // R2 disabled
    '{1'b1, 2'd3, 2'd0, 4'h0, 1'b1, 1'b0, 16'd0,    4'd2, 4'h0, 1'b0}, // R2 mode 0
    '{1'b1, 2'd1, 2'd1, 4'h0, 1'b0, 1'b1, 16'd319,  4'd1, 4'h0, 1'b1}, // R3
    '{1'b1, 2'd1, 2'd1, 4'h0, 1'b0, 1'b1, 16'd320,  4'd1, 4'h0, 1'b0}, // R6
    '{1'b1, 2'd3, 2'd1, 4'h0, 1'b0, 1'b1, 16'd320,  4'd1, 4'h0, 1'b1}, // R6
    '{1'b1, 2'd3, 2'd1, 4'h0, 1'b1, 1'b0, 16'd0,    4'd1, 4'h0, 1'b0}, // R3 l2
    '{1'b1, 2'd1, 2'd1, 4'h0, 1'b0, 1'b1, 16'd319,  4'd2, 4'h0, 1'b0}, // R3 ver
    '{1'b1, 2'd0, 2'd2, 4'hF, 1'b1, 1'b0, 16'd0,    4'd2, 4'hB, 1'b1}, // R4 wildcard
    '{1'b1, 2'd0, 2'd2, 4'h3, 1'b1, 1'b0, 16'd0,    4'd2, 4'h3, 1'b1}, // R4 exact
    '{1'b1, 2'd0, 2'd2, 4'h3, 1'b1, 1'b0, 16'd0,    4'd2, 4'h2, 1'b0}, // R4 miss
    '{1'b1, 2'd1, 2'd3, 4'h9, 1'b1, 1'b0, 16'd0,    4'd2, 4'h1, 1'b1}, // R5 match ignored
    '{1'b1, 2'd1, 2'd3, 4'h8, 1'b1, 1'b0, 16'd0,    4'd2, 4'h8, 1'b0}, // R5 type 8
    '{1'b1, 2'd1, 2'd3, 4'h0, 1'b0, 1'b1, 16'd319,  4'd2, 4'h7, 1'b1}, // R5 udp
    '{1'b1, 2'd0, 2'd3, 4'h0, 1'b0, 1'b1, 16'd319,  4'd2, 4'h0, 1'b0}, // R6 no ports
    '{1'b1, 2'd3, 2'd3, 4'h0, 1'b0, 1'b1, 16'd320,  4'd2, 4'h0, 1'b1}, // R6 both
    '{1'b1, 2'd3, 2'd3, 4'h0, 1'b0, 1'b1, 16'd1234, 4'd2, 4'h0, 1'b0}, // R6 other port
    '{1'b1, 2'd3, 2'd3, 4'h0, 1'b0, 1'b0, 16'd0,    4'd2, 4'h0, 1'b0}  // R6 no transport
  };

  function automatic logic [31:0] ctl_word(logic en, logic [1:0] ports, logic [1:0] mode,
                                           logic [3:0] match);
    return {en, 3'b0, ports, mode, 4'b0, match, 16'b0};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic frame(logic l2, logic udp, logic [15:0] dp, logic [3:0] ver,
                       logic [3:0] typ, logic [63:0] t);
    frm_vld = 1; frm_l2 = l2; frm_udp = udp; frm_dport = dp;
    frm_ver = ver; frm_type = typ; tstamp = t;
    @(negedge clk);
    frm_vld = 0;
  endtask

  function automatic logic [63:0] tsv(int k);
    return {8'hC0 + 8'(k), 24'h0, 32'h1000 + 32'(k)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 valid", 64'(slot_vld), 64'h0);
    rd(4'd0, d); check("R1 ctl", 64'(d), 64'h0);
    rd(4'd1, d); check("R1 drop", 64'(d), 64'h0);

    // table of filter cases
    for (int i = 0; i < NV; i++) begin
      t = {32'hA500_0000 + 32'(i), 32'h5A00_0000 + 32'(i)};
      wr(4'd0, ctl_word(VEC[i].en, VEC[i].ports, VEC[i].mode, VEC[i].match));
      frame(VEC[i].l2, VEC[i].udp, VEC[i].dport, VEC[i].ver, VEC[i].typ, t);
      check($sformatf("R2-R6 vec %0d", i), 64'(slot_vld), VEC[i].exp ? 64'h1 : 64'h0);
      if (VEC[i].exp) begin
        rd(4'd2, d); check("R7 low word", 64'(d), 64'(t[31:0]));
        rd(4'd3, d); check("R8 high word", 64'(d), 64'(t[63:32]));
        check("R9 released", 64'(slot_vld), 64'h0);
      end
    end

    // R8 control readback
    wr(4'd0, ctl_word(1'b1, 2'd1, 2'd3, 4'h0) | 32'h0000_00A5);
    rd(4'd0, d); check("R8 ctl readback", 64'(d), 64'(ctl_word(1'b1, 2'd1, 2'd3, 4'h0) | 32'h0000_00A5));

    // R7 lowest free slot ordering
    for (int k = 0; k < 4; k++) begin
      frame(1'b1, 1'b0, 16'd0, 4'd2, 4'd0, tsv(k));
      check("R7 fill", 64'(slot_vld), 64'((1 << (k + 1)) - 1));
    end
    rd(4'd5, d); check("R9 slot1 high", 64'(d), 64'(tsv(1) >> 32));
    check("R9 slot1 freed", 64'(slot_vld), 64'hD);
    frame(1'b1, 1'b0, 16'd0, 4'd2, 4'd0, tsv(4));
    check("R7 refill", 64'(slot_vld), 64'hF);
    rd(4'd4, d); check("R7 slot1 low", 64'(d), 64'(tsv(4)) & 64'hFFFF_FFFF);

    // R10 release of slot2 together with a new capture
    reg_rd = 1; reg_addr = 4'd7;
    frm_vld = 1; frm_l2 = 1; frm_udp = 0; frm_ver = 4'd2; frm_type = 4'd1; tstamp = tsv(5);
    @(negedge clk);
    reg_rd = 0; frm_vld = 0;
    check("R10 old high", 64'(reg_rdata), 64'(tsv(2) >> 32));
    check("R10 still valid", 64'(slot_vld), 64'hF);
    rd(4'd6, d); check("R10 new low", 64'(d), 64'(tsv(5)) & 64'hFFFF_FFFF);
    rd(4'd1, d); check("R10 no drop", 64'(d), 64'h0);

    // R11 drops with a full pool
    frame(1'b1, 1'b0, 16'd0, 4'd2, 4'd0, tsv(6));
    rd(4'd1, d); check("R11 first drop", 64'(d), 64'h1);
    rd(4'd2, d); check("R11 slot0 kept", 64'(d), 64'(tsv(0)) & 64'hFFFF_FFFF);
    for (int j = 0; j < 300; j++) frame(1'b1, 1'b0, 16'd0, 4'd2, 4'd0, tsv(7));
    rd(4'd1, d); check("R11 saturated", 64'(d), 64'hFF);
    check("R11 pool full", 64'(slot_vld), 64'hF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule